// File: doc/BRIEF.md
# Bus Hold Request Controller

This block runs the handshake through which an external master borrows the system bus. It watches an active-low hold request. It decides when that request may be sampled, based on the current bus activity. Once it accepts a request, it stops the CPU clock, lowers an active-low acknowledge and then floats the bus pins. When the master withdraws, it gives the bus back in the reverse order.

All decisions are made on the bus-interface clock. The request passes through a synchronizer on the falling edge. Sampling decisions are also taken on the falling edge, and state changes happen on the rising edge. A clock-enable input stands for the bus clock being frozen, as happens during a ready wait or a low-power mode. While the enable is low, nothing is sampled and nothing moves.

Top module: `bus_hold_ctrl`

## Requirements
- R1: After reset `hold_ack_n` is 1, `bus_oe` is 1 and `cpu_clk_en` is 1.
- R2: With `bus_busy` low, the request is sampled on every enabled falling edge. A low level that is stable from before an enabled falling edge drives `hold_ack_n` low at the first rising edge after the third enabled falling edge that sees it.
- R3: With `bus_busy` high and `split_first` low, the request is sampled only on falling edges where `cyc_strobe` is 1. A strobe seen at a falling edge, with the request low and synchronized, lowers `hold_ack_n` at the next rising edge.
- R4: While `split_first` is 1 with `bus_busy` high, `cyc_strobe` is ignored and no request is accepted.
- R5: `cpu_clk_en` falls on the same rising edge as `hold_ack_n`. `bus_oe` falls exactly one enabled rising edge later.
- R6: In the hold state, the request is sampled on every enabled falling edge, whatever the values of `bus_busy`, `cyc_strobe` and `split_first`. A high level raises `hold_ack_n` with the same three-falling-edge latency as R2.
- R7: `bus_oe` and `cpu_clk_en` both return to 1 exactly one enabled rising edge after `hold_ack_n` rises.
- R8: While `clk_en` is 0, no sampling takes place and no output changes. The synchronizer holds its contents, so the R2 latency counts only enabled falling edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus-interface clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en | input | 1 | Bus clock running; 0 models a frozen clock |
| hold_req_n | input | 1 | Active-low hold request from the external master |
| bus_busy | input | 1 | A bus cycle is in progress |
| cyc_strobe | input | 1 | Decision point of the current bus cycle |
| split_first | input | 1 | First half of a two-cycle odd-address word access |
| cpu_clk_en | output | 1 | Enable for the CPU clock, registered |
| hold_ack_n | output | 1 | Active-low hold acknowledge, registered |
| bus_oe | output | 1 | Output enable for the address/data, read/write and byte-high pins |

## Verification
A wrong state in this controller shows up at the ports within one rising edge. A sequencer that skips a step produces `bus_oe` moving on the same edge as `hold_ack_n`, or with no edge between them. An acknowledge that never returns leaves `cpu_clk_en` stuck low. A sampler that ignores the bus-activity rules lowers `hold_ack_n` while a bus cycle runs without a strobe, or during the first half of a split access. A synchronizer or enable fault shifts the acceptance edge by one or more cycles. The bench compares all three outputs against its reference model on every clock, so any such shift appears in the very next comparison.

// File: rtl/bus_hold_pkg.sv
package bus_hold_pkg;
  typedef enum logic [1:0] {
    HS_IDLE        = 2'd0,
    HS_FLOAT_WAIT  = 2'd1,
    HS_HOLD        = 2'd2,
    HS_RESUME_WAIT = 2'd3
  } hold_st_e;
endpackage

// File: rtl/hold_req_sync.sv
module hold_req_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clk_en,
  input  logic req_n,
  output logic req_n_s
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain_q;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) chain_q[0] <= 1'b1;
    else if (clk_en) chain_q[0] <= req_n;
  end

  generate
    for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[i] <= 1'b1;
        else if (clk_en) chain_q[i] <= chain_q[i-1];
      end
    end
  endgenerate

  assign req_n_s = chain_q[LAST];
endmodule

// File: rtl/hold_sampler.sv
module hold_sampler
  import bus_hold_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     clk_en,
  input  logic     req_n_s,
  input  hold_st_e st,
  input  logic     bus_busy,
  input  logic     cyc_strobe,
  input  logic     split_first,
  output logic     samp_vld,
  output logic     samp_low
);
  logic idle_ok;
  logic take;

  always_comb begin
    idle_ok = !bus_busy || (cyc_strobe && !split_first);
    unique case (st)
      HS_IDLE: take = idle_ok;
      HS_HOLD: take = 1'b1;
      default: take = 1'b0;
    endcase
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp_vld <= 1'b0;
      samp_low <= 1'b0;
    end else begin
      samp_vld <= clk_en && take;
      if (clk_en) samp_low <= !req_n_s;
    end
  end

  // R4: the first half of a split access never yields a decision
  p_no_split_sample_r4: assert property (@(negedge clk) disable iff (!rst_n)
    (clk_en && st == HS_IDLE && bus_busy && split_first) |=> !samp_vld);

  // R3: a busy bus without a strobe never yields a decision
  p_busy_needs_strobe_r3: assert property (@(negedge clk) disable iff (!rst_n)
    (st == HS_IDLE && bus_busy && !cyc_strobe) |=> !samp_vld);
endmodule

// File: rtl/hold_fsm.sv
module hold_fsm
  import bus_hold_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     clk_en,
  input  logic     samp_vld,
  input  logic     samp_low,
  output hold_st_e st,
  output logic     cpu_clk_en,
  output logic     hold_ack_n,
  output logic     bus_oe
);
  hold_st_e st_d;
  logic     ack_n_d, oe_d, cpu_d;

  always_comb begin
    st_d = st;
    unique case (st)
      HS_IDLE:        if (samp_vld && samp_low)  st_d = HS_FLOAT_WAIT;
      HS_FLOAT_WAIT:                             st_d = HS_HOLD;
      HS_HOLD:        if (samp_vld && !samp_low) st_d = HS_RESUME_WAIT;
      HS_RESUME_WAIT:                            st_d = HS_IDLE;
      default:                                   st_d = HS_IDLE;
    endcase
    ack_n_d = !(st_d == HS_FLOAT_WAIT || st_d == HS_HOLD);
    oe_d    = !(st_d == HS_HOLD || st_d == HS_RESUME_WAIT);
    cpu_d   = (st_d == HS_IDLE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= HS_IDLE;
      hold_ack_n <= 1'b1;
      bus_oe     <= 1'b1;
      cpu_clk_en <= 1'b1;
    end else if (clk_en) begin
      st         <= st_d;
      hold_ack_n <= ack_n_d;
      bus_oe     <= oe_d;
      cpu_clk_en <= cpu_d;
    end
  end

  // R5: bus floats only after a full cycle of low acknowledge
  p_float_after_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_oe) |-> (!hold_ack_n && $past(!hold_ack_n)));

  // R5: cpu clock stops together with the acknowledge
  p_cpu_stop_with_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_ack_n) |-> (!cpu_clk_en && bus_oe));

  // R7: drivers and cpu clock return one cycle after the acknowledge rises
  p_resume_after_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_oe) |-> (hold_ack_n && $past(hold_ack_n) && cpu_clk_en));

  // R8: a frozen clock freezes the sequencer
  p_frozen_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(clk_en) |-> ($stable(st) && $stable(hold_ack_n) && $stable(bus_oe)));
endmodule

// File: rtl/bus_hold_ctrl.sv
module bus_hold_ctrl
  import bus_hold_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clk_en,
  input  logic hold_req_n,
  input  logic bus_busy,
  input  logic cyc_strobe,
  input  logic split_first,
  output logic cpu_clk_en,
  output logic hold_ack_n,
  output logic bus_oe
);
  logic     req_n_s;
  logic     samp_vld, samp_low;
  hold_st_e st;

  hold_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .clk_en  (clk_en),
    .req_n   (hold_req_n),
    .req_n_s (req_n_s)
  );

  hold_sampler u_samp (
    .clk         (clk),
    .rst_n       (rst_n),
    .clk_en      (clk_en),
    .req_n_s     (req_n_s),
    .st          (st),
    .bus_busy    (bus_busy),
    .cyc_strobe  (cyc_strobe),
    .split_first (split_first),
    .samp_vld    (samp_vld),
    .samp_low    (samp_low)
  );

  hold_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .clk_en     (clk_en),
    .samp_vld   (samp_vld),
    .samp_low   (samp_low),
    .st         (st),
    .cpu_clk_en (cpu_clk_en),
    .hold_ack_n (hold_ack_n),
    .bus_oe     (bus_oe)
  );
endmodule

// File: tb/bus_hold_ctrl_tb.sv
module bus_hold_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clk_en = 1'b1;
  logic hold_req_n = 1'b1;
  logic bus_busy = 1'b0;
  logic cyc_strobe = 1'b0;
  logic split_first = 1'b0;
  logic cpu_clk_en, hold_ack_n, bus_oe;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  bus_hold_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .hold_req_n(hold_req_n),
    .bus_busy(bus_busy), .cyc_strobe(cyc_strobe), .split_first(split_first),
    .cpu_clk_en(cpu_clk_en), .hold_ack_n(hold_ack_n), .bus_oe(bus_oe)
  );

  // behavioural reference: 0 idle, 1 float pending, 2 holding, 3 resume pending
  int ms;
  bit m_ack, m_oe, m_cpu, m_sv, m_sl;
  bit hist[$];

  always @(negedge clk) begin
    if (!rst_n) begin
      hist = {1'b1, 1'b1};
      m_sv = 0;
      m_sl = 0;
    end else begin
      m_sv = clk_en && ((ms == 2) || (ms == 0 && (!bus_busy || (cyc_strobe && !split_first))));
      if (clk_en) begin
        m_sl = !hist[hist.size()-2];
        hist.push_back(hold_req_n);
        if (hist.size() > 3) void'(hist.pop_front());
      end
    end
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      ms = 0; m_ack = 1; m_oe = 1; m_cpu = 1;
    end else if (clk_en) begin
      case (ms)
        0: if (m_sv && m_sl) begin ms = 1; m_ack = 0; m_cpu = 0; end
        1: begin ms = 2; m_oe = 0; end
        2: if (m_sv && !m_sl) begin ms = 3; m_ack = 1; end
        default: begin ms = 0; m_oe = 1; m_cpu = 1; end
      endcase
    end
  end

  always @(posedge clk) begin
    if (rst_n && !done) begin
      #13;
      n_chk++;
      if ({hold_ack_n, bus_oe, cpu_clk_en} !== {m_ack, m_oe, m_cpu}) begin
        n_fail++;
        $display("FAIL model R2 R3 R4 R5 R6 R7 R8: ack/oe/cpu actual %b%b%b expected %b%b%b",
                 hold_ack_n, bus_oe, cpu_clk_en, m_ack, m_oe, m_cpu);
      end
    end
  end

  task automatic chk(string tag, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #13;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #4_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    chk("R1 ack", hold_ack_n, 1'b1);
    chk("R1 oe", bus_oe, 1'b1);
    chk("R1 cpu", cpu_clk_en, 1'b1);

    // idle acceptance
    hold_req_n = 1'b0;
    tick(3);
    chk("R2 ack before latency", hold_ack_n, 1'b1);
    tick(1);
    chk("R2 ack accepted", hold_ack_n, 1'b0);
    chk("R5 cpu stops with ack", cpu_clk_en, 1'b0);
    chk("R5 oe still driven", bus_oe, 1'b1);
    tick(1);
    chk("R5 oe floats", bus_oe, 1'b0);

    // release while busy without strobe: still sampled in hold
    bus_busy = 1'b1;
    hold_req_n = 1'b1;
    tick(3);
    chk("R6 ack still low", hold_ack_n, 1'b0);
    tick(1);
    chk("R6 ack rises", hold_ack_n, 1'b1);
    chk("R7 oe still off", bus_oe, 1'b0);
    tick(1);
    chk("R7 oe back", bus_oe, 1'b1);
    chk("R7 cpu back", cpu_clk_en, 1'b1);

    // busy bus, no strobe
    hold_req_n = 1'b0;
    tick(10);
    chk("R3 no strobe no accept", hold_ack_n, 1'b1);
    cyc_strobe = 1'b1;
    tick(1);
    cyc_strobe = 1'b0;
    chk("R3 before strobe edge", hold_ack_n, 1'b1);
    tick(1);
    chk("R3 strobe accepts", hold_ack_n, 1'b0);
    tick(1);
    hold_req_n = 1'b1;
    tick(6);
    chk("R6 released", hold_ack_n, 1'b1);

    // split odd-address access
    hold_req_n = 1'b0;
    cyc_strobe = 1'b1;
    split_first = 1'b1;
    tick(6);
    chk("R4 first half ignored", hold_ack_n, 1'b1);
    split_first = 1'b0;
    tick(1);
    chk("R4 second half pending", hold_ack_n, 1'b1);
    tick(1);
    chk("R4 second half accepts", hold_ack_n, 1'b0);
    cyc_strobe = 1'b0;
    hold_req_n = 1'b1;
    tick(6);
    chk("R6 released after split", hold_ack_n, 1'b1);
    bus_busy = 1'b0;
    tick(2);

    // frozen clock in idle
    clk_en = 1'b0;
    hold_req_n = 1'b0;
    tick(8);
    chk("R8 frozen no accept", hold_ack_n, 1'b1);
    clk_en = 1'b1;
    tick(3);
    chk("R8 latency restarts", hold_ack_n, 1'b1);
    tick(1);
    chk("R8 accepted after thaw", hold_ack_n, 1'b0);
    tick(2);

    // frozen clock in hold
    clk_en = 1'b0;
    hold_req_n = 1'b1;
    tick(8);
    chk("R8 hold kept frozen", hold_ack_n, 1'b0);
    chk("R8 oe kept frozen", bus_oe, 1'b0);
    clk_en = 1'b1;
    tick(4);
    chk("R6 release after thaw", hold_ack_n, 1'b1);
    tick(1);
    chk("R7 oe after thaw", bus_oe, 1'b1);
    tick(3);
    finish_run();
  end
endmodule